// File: doc/BRIEF.md
# Shared Memory Arbiter with Write Posting

This block lets a processor and a second bus master share one single-port memory. The processor holds `cpu_req` for the whole of a bus cycle. The cycle completes on the first rising clock edge at which `cpu_wait_n` is high, so the block can stretch a cycle by any number of clocks. The second master raises `ext_req` and may use the memory in every cycle in which `ext_gnt` is high.

Ownership is re-decided at every rising edge, and every clock is one memory cycle. The owner register has four states:

- OWN_IDLE: no owner, so the memory is quiet.
- OWN_CPU: the processor accesses the memory directly.
- OWN_EXT: the second master owns the memory.
- OWN_DRAIN: a one-cycle state that commits a parked processor write.

Every state can move to every other state through the same arbitration rule:

- A side that alone wants the memory wins.
- A tie goes to the side that `CPU_PRIO` selects.
- A processor win moves to OWN_DRAIN if a write is still parked, and to OWN_CPU otherwise.
- With no wanter, the owner moves to OWN_IDLE.

While the processor does not own the memory, a processor write is parked in a one-entry holding register and its cycle completes without a wait state. A processor read is different. It returns the parked data if its address matches the parked write. Otherwise it stalls until the processor side owns the memory. The memory is read combinationally: `mem_rdata` is valid in the same cycle as `mem_addr`.

Top module: `shared_mem_arbiter`

## Requirements
- R1: After reset the owner is OWN_IDLE, the holding register is empty, `ext_gnt` is 0, `mem_en` is 0, and `cpu_wait_n` is 1 while `cpu_req` is 0.
- R2: In OWN_CPU a processor request (`cpu_we`=1 write, 0 read) completes in its first cycle with `cpu_wait_n`=1. It accesses the memory at `cpu_addr`, and a read returns `mem_rdata`.
- R3: In OWN_EXT, `ext_gnt` is 1. Every cycle with `ext_req`=1 is one memory access using the `ext_*` signals, and `ext_rdata` carries the memory word.
- R4: A processor read while the processor side does not own the memory, and that does not hit the parked write, is held with `cpu_wait_n`=0 until the processor owns the memory.
- R5: A processor write while the processor does not own the memory and the holding register is empty completes in that cycle with `cpu_wait_n`=1. It is parked and not written to the memory in that cycle.
- R6: A parked write is committed to the memory in OWN_DRAIN, which lasts exactly one cycle and is the first cycle of processor ownership. A processor request in that cycle gets `cpu_wait_n`=0.
- R7: A processor write that arrives while the holding register is full gets `cpu_wait_n`=0 until the parked write has drained.
- R8: A processor read whose address equals that of the parked write, outside OWN_DRAIN, completes at once and returns the parked data.
- R9: At each rising edge the processor side wants the memory if `cpu_req` is 1 or a write is parked, and the second master wants it if `ext_req` is 1. A sole wanter wins. A tie goes to the processor when `CPU_PRIO`=1 and to the second master when `CPU_PRIO`=0. The grant is visible from the following cycle.
- R10: When neither side wants the memory the owner becomes OWN_IDLE, and `mem_en` stays 0 in OWN_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor bus cycle active |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| cpu_wait_n | output | 1 | Active-low stall for the processor cycle |
| ext_req | input | 1 | Second master request and access strobe |
| ext_we | input | 1 | Second master write (1) or read (0) |
| ext_addr | input | AW | Second master address |
| ext_wdata | input | DW | Second master write data |
| ext_rdata | output | DW | Second master read data |
| ext_gnt | output | 1 | Second master owns the memory |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |

## Verification
Several rules are checked on every cycle:

- Foreign reads that miss the parked write stall.
- Parked writes never stall, and a second write against a full register does.
- A parked write never coexists with processor ownership, and the drain lasts a single cycle.
- The idle state leaves the memory quiet.
- Hits return the parked word.

The bench's long mixed scenarios are needed for the rest. These cover that committed data reaches the right address in the right order, the tie-break under the chosen priority, and that reads after a drain see the new contents. They also cover the exact cycle in which a stalled request is finally served.

// File: rtl/sma_pkg.sv
package sma_pkg;

    // Memory owner for the current clock cycle.
    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_CPU   = 2'd1,
        OWN_EXT   = 2'd2,
        OWN_DRAIN = 2'd3
    } owner_e;

endpackage

// File: rtl/sma_owner_fsm.sv
module sma_owner_fsm
    import sma_pkg::*;
#(
    parameter bit CPU_PRIO = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cpu_want,
    input  logic   ext_want,
    input  logic   post_next,
    output owner_e state
);

    owner_e nxt;
    logic   pick_cpu;
    logic   pick_ext;

    // Tie-break between the two sides.
    always_comb begin
        pick_cpu = cpu_want && (!ext_want || CPU_PRIO);
        pick_ext = ext_want && (!cpu_want || !CPU_PRIO);
    end

    // Next-state logic: the same arbitration applies at every memory-cycle boundary.
    always_comb begin
        nxt = OWN_IDLE;
        unique case (state)
            OWN_IDLE, OWN_CPU, OWN_EXT, OWN_DRAIN: begin
                if (pick_ext) begin
                    nxt = OWN_EXT;
                end else if (pick_cpu) begin
                    nxt = post_next ? OWN_DRAIN : OWN_CPU;
                end else begin
                    nxt = OWN_IDLE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OWN_IDLE;
        end else begin
            state <= nxt;
        end
    end

    AST_DRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == OWN_DRAIN |=> state != OWN_DRAIN); // R6

    AST_SOLE_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_want && !cpu_want |=> state == OWN_EXT); // R9

endmodule

// File: rtl/sma_post_buf.sv
module sma_post_buf #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          drain,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [AW-1:0] look_addr,
    output logic          full,
    output logic          full_next,
    output logic          hit,
    output logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_data
);

    // The next value of full is used as the processor side's pending demand.
    always_comb begin
        full_next = (full && !drain) || load;
        hit       = full && (p_addr == look_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            full <= full_next;
            if (load) begin
                p_addr <= in_addr;
                p_data <= in_data;
            end
        end
    end

    AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full); // R7

    AST_POST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full && p_addr == $past(in_addr) && p_data == $past(in_data)); // R5

endmodule

// File: rtl/sma_access_ctrl.sv
module sma_access_ctrl
    import sma_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  owner_e        state,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          ext_req,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    input  logic          buf_full,
    input  logic          buf_hit,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_data,
    input  logic [DW-1:0] mem_rdata,
    output logic          cpu_wait_n,
    output logic [DW-1:0] cpu_rdata,
    output logic [DW-1:0] ext_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          buf_load,
    output logic          buf_drain
);

    // Processor handling while the other side (or nobody) owns the memory.
    logic          f_wait_n;
    logic          f_load;
    logic          f_fwd;

    always_comb begin
        f_wait_n = 1'b1;
        f_load   = 1'b0;
        f_fwd    = 1'b0;
        if (cpu_req) begin
            if (cpu_we) begin
                if (!buf_full) begin
                    f_load = 1'b1;
                end else begin
                    f_wait_n = 1'b0;
                end
            end else if (buf_hit) begin
                f_fwd = 1'b1;
            end else begin
                f_wait_n = 1'b0;
            end
        end
    end

    // Output process, one branch per owner state.
    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cpu_addr;
        mem_wdata  = cpu_wdata;
        cpu_wait_n = 1'b1;
        cpu_rdata  = mem_rdata;
        ext_rdata  = mem_rdata;
        buf_load   = 1'b0;
        buf_drain  = 1'b0;
        unique case (state)
            OWN_IDLE: begin
                cpu_wait_n = f_wait_n;
                buf_load   = f_load;
                if (f_fwd) begin
                    cpu_rdata = buf_data;
                end
            end
            OWN_CPU: begin
                mem_en = cpu_req;
                mem_we = cpu_req && cpu_we;
            end
            OWN_EXT: begin
                mem_en     = ext_req;
                mem_we     = ext_req && ext_we;
                mem_addr   = ext_addr;
                mem_wdata  = ext_wdata;
                cpu_wait_n = f_wait_n;
                buf_load   = f_load;
                if (f_fwd) begin
                    cpu_rdata = buf_data;
                end
            end
            OWN_DRAIN: begin
                mem_en     = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = buf_addr;
                mem_wdata  = buf_data;
                buf_drain  = 1'b1;
                cpu_wait_n = !cpu_req;
            end
        endcase
    end

endmodule

// File: rtl/shared_mem_arbiter.sv
module shared_mem_arbiter
    import sma_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter bit CPU_PRIO = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait_n,
    input  logic          ext_req,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    output logic [DW-1:0] ext_rdata,
    output logic          ext_gnt,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    owner_e        state;
    logic          buf_full;
    logic          buf_full_next;
    logic          buf_hit;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic          buf_load;
    logic          buf_drain;
    logic          cpu_want;

    assign cpu_want = cpu_req || buf_full_next;
    assign ext_gnt  = (state == OWN_EXT);

    sma_owner_fsm #(
        .CPU_PRIO(CPU_PRIO)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_want (cpu_want),
        .ext_want (ext_req),
        .post_next(buf_full_next),
        .state    (state)
    );

    sma_post_buf #(
        .AW(AW),
        .DW(DW)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (buf_load),
        .drain    (buf_drain),
        .in_addr  (cpu_addr),
        .in_data  (cpu_wdata),
        .look_addr(cpu_addr),
        .full     (buf_full),
        .full_next(buf_full_next),
        .hit      (buf_hit),
        .p_addr   (buf_addr),
        .p_data   (buf_data)
    );

    sma_access_ctrl #(
        .AW(AW),
        .DW(DW)
    ) u_ctrl (
        .state     (state),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .ext_req   (ext_req),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .buf_full  (buf_full),
        .buf_hit   (buf_hit),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .mem_rdata (mem_rdata),
        .cpu_wait_n(cpu_wait_n),
        .cpu_rdata (cpu_rdata),
        .ext_rdata (ext_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .buf_load  (buf_load),
        .buf_drain (buf_drain)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ext_gnt && !mem_en && !buf_full); // R1

    AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt && cpu_req && !cpu_we && !(buf_full && buf_addr == cpu_addr) |-> !cpu_wait_n); // R4

    AST_WRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        state != OWN_DRAIN && cpu_req && cpu_we && !buf_full |-> cpu_wait_n); // R5

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && cpu_req && cpu_we |-> !cpu_wait_n); // R7

    AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> state != OWN_CPU); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == OWN_IDLE |-> !mem_en); // R10

    AST_HIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        state != OWN_DRAIN && cpu_req && !cpu_we && buf_full && buf_addr == cpu_addr
        |-> cpu_wait_n && cpu_rdata == buf_data); // R8

    AST_CPU_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        state == OWN_CPU && cpu_req |-> cpu_wait_n && mem_en && mem_addr == cpu_addr); // R2

endmodule

// File: tb/shared_mem_arbiter_bench.sv
module shared_mem_arbiter_bench;

    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam bit PRIO = 1'b0;
    localparam int NCYC = 4000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we, ext_req, ext_we;
    logic [AW-1:0] cpu_addr, ext_addr;
    logic [DW-1:0] cpu_wdata, ext_wdata;
    logic [DW-1:0] cpu_rdata, ext_rdata, mem_rdata, mem_wdata;
    logic          cpu_wait_n, ext_gnt, mem_en, mem_we;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    shared_mem_arbiter #(.AW(AW), .DW(DW), .CPU_PRIO(PRIO)) u_shared_mem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_wait_n(cpu_wait_n),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_gnt(ext_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory device driven by the block.
    logic [DW-1:0] ram [0:15];
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ram[i] <= DW'(i * 7 + 3);
        end else if (mem_en && mem_we) begin
            ram[mem_addr] <= mem_wdata;
        end
    end

    // Reference model: 0 none, 1 processor, 2 second master, 3 commit.
    int            own;
    bit            pv;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    logic [DW-1:0] ref_mem [0:15];
    bit            d_done, d_rdv, d_post, d_drain, d_cpu_wr, d_men;
    logic [DW-1:0] d_rd;
    string         d_tag;
    bit            cpu_done_q;
    bit            running;
    int            total = 0;
    int            bad = 0;
    int            cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Decide and compare in the middle of each cycle.
    always @(negedge clk) begin
        if (rst_n && running) begin
            d_done = 0; d_rdv = 0; d_post = 0; d_drain = 0; d_cpu_wr = 0; d_men = 0;
            d_rd = '0; d_tag = "R2";
            case (own)
                1: begin
                    d_men = cpu_req;
                    if (cpu_req) begin
                        d_done = 1;
                        if (cpu_we) d_cpu_wr = 1;
                        else begin d_rdv = 1; d_rd = ref_mem[cpu_addr]; end
                    end
                end
                3: begin
                    d_men = 1; d_drain = 1; d_tag = "R6";
                end
                default: begin
                    d_men = (own == 2) && ext_req;
                    if (cpu_req) begin
                        if (cpu_we) begin
                            if (!pv) begin d_post = 1; d_done = 1; d_tag = "R5"; end
                            else d_tag = "R7";
                        end else if (pv && pa == cpu_addr) begin
                            d_done = 1; d_rdv = 1; d_rd = pd; d_tag = "R8";
                        end else begin
                            d_tag = "R4";
                        end
                    end
                end
            endcase
            chk(cpu_wait_n == !(cpu_req && !d_done), d_tag, "cpu_wait_n",
                32'(cpu_wait_n), 32'(!(cpu_req && !d_done)));
            if (d_rdv) chk(cpu_rdata == d_rd, d_tag, "cpu_rdata", 32'(cpu_rdata), 32'(d_rd));
            chk(ext_gnt == (own == 2), "R9", "ext_gnt", 32'(ext_gnt), 32'(own == 2));
            if (own == 2 && ext_req && !ext_we)
                chk(ext_rdata == ref_mem[ext_addr], "R3", "ext_rdata",
                    32'(ext_rdata), 32'(ref_mem[ext_addr]));
            chk(mem_en == d_men, "R10", "mem_en", 32'(mem_en), 32'(d_men));
        end
    end

    // Model state update at the clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            own = 0; pv = 0; pa = '0; pd = '0; cpu_done_q = 0;
            d_done = 0; d_rdv = 0; d_post = 0; d_drain = 0; d_cpu_wr = 0; d_men = 0;
            for (int i = 0; i < 16; i++) ref_mem[i] = DW'(i * 7 + 3);
        end else if (running) begin
            bit wc, we_;
            if (d_cpu_wr) ref_mem[cpu_addr] = cpu_wdata;
            if (own == 2 && ext_req && ext_we) ref_mem[ext_addr] = ext_wdata;
            if (d_drain) begin ref_mem[pa] = pd; pv = 0; end
            if (d_post) begin pv = 1; pa = cpu_addr; pd = cpu_wdata; end
            cpu_done_q = d_done;
            wc  = cpu_req || pv;
            we_ = ext_req;
            if (we_ && (!wc || !PRIO)) own = 2;
            else if (wc) own = pv ? 3 : 1;
            else own = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        running = 0;
        rst_n = 0;
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        ext_req = 0; ext_we = 0; ext_addr = '0; ext_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ext_gnt == 1'b0, "R1", "ext_gnt in reset", 32'(ext_gnt), 32'd0);
        chk(cpu_wait_n == 1'b1, "R1", "cpu_wait_n in reset", 32'(cpu_wait_n), 32'd1);
        @(posedge clk); #1;
        rst_n = 1; running = 1;
        @(negedge clk);
        chk(mem_en == 1'b0, "R1", "mem_en after reset", 32'(mem_en), 32'd0);
        chk(ext_gnt == 1'b0, "R1", "ext_gnt after reset", 32'(ext_gnt), 32'd0);
        for (int c = 0; c < NCYC; c++) begin
            int p;
            @(posedge clk); #1;
            case ((c / 500) % 4)
                0: p = 10;
                1: p = 60;
                2: p = 95;
                default: p = 0;
            endcase
            ext_req   = (($urandom % 100) < p);
            ext_we    = 1'($urandom % 2);
            ext_addr  = AW'($urandom % 8);
            ext_wdata = DW'($urandom);
            if (!cpu_req || cpu_done_q) begin
                if (($urandom % 100) < 70) begin
                    cpu_req   = 1;
                    cpu_we    = 1'($urandom % 2);
                    cpu_addr  = AW'($urandom % 8);
                    cpu_wdata = DW'($urandom);
                end else begin
                    cpu_req = 0;
                end
            end
        end
        @(posedge clk); #1;
        if (cpu_req && !cpu_done_q) begin
            ext_req = 0;
            while (!cpu_done_q) begin @(posedge clk); #1; end
        end
        cpu_req = 0; ext_req = 0;
        repeat (4) @(posedge clk);
        #1;
        for (int i = 0; i < 16; i++)
            chk(ram[i] == ref_mem[i], "R6", "memory word", 32'(ram[i]), 32'(ref_mem[i]));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule